// File: doc/BRIEF.md
# Robust-Mode Interleaver Parameter Calculator

This block works out the interleaver settings for one of three robust modulation modes, in which each symbol carries several redundant copies of the data. A request gives the number of active carriers and a 2-bit mode select. The block then derives the segment size and the number of pad bits that fill the final segment. It also picks a cyclic shift for each copy, based on how much of the final symbol the coded data fills. It returns all of this as two packed 32-bit configuration words that a neighbouring interleaver can load directly.

The arithmetic uses three divisions in sequence. A single shared restoring divider, one quotient bit per cycle, does all of them, so the block needs no multiplier or divider macro. A one-cycle `start` begins a request. `busy` is high while the request runs. `done` pulses for one cycle when the results are ready. The results then hold until a later request completes. A request that would divide by zero, or that names the unused mode code, finishes at once with an error flag and all-zero words.

Top module: `robo_ilv_calc`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `error`, `cfgWord0` and `cfgWord1` are all zero.
- R2: Mode codes are 0 = four copies with 8320 raw bits, 1 = two copies with 8320 raw bits, and 2 = five copies with 2176 raw bits. A start with mode code 3, or with a carrier count below the copy count, raises `done` and `error` in the next cycle with both words zero. A successful request clears `error`.
- R3: An accepted valid start raises `busy` from the next cycle. It raises `done` for exactly one cycle, 51 clock edges after the start edge (3·16+3 with the default divider width), and `busy` is low in that cycle.
- R4: `cfgWord0[31:16]` holds the segment bit count, 2·floor(carriers / copies).
- R5: `cfgWord0[15:0]` holds the pad count, defined as follows. The symbol size is the segment bit count times the copy count. L is the raw bit count modulo the symbol size, or the full symbol size when that remainder is zero. The pad count is the segment size minus the bits in the last segment, and the bits in the last segment are L − seg·floor((L−1)/seg).
- R6: In mode 0 the four 3-bit shifts, with copy k at `cfgWord1[3k+2:3k]`, are all 0 when L ≤ seg. They are 0,0,1,1 when L ≤ 2·seg, all 0 when L ≤ 3·seg, and 0,1,2,3 otherwise.
- R7: In mode 1 the two shifts are 0,0 when L ≤ seg, else 0,1. Unused shift fields are zero.
- R8: In mode 2 the five shifts are all 0 when L ≤ 4·seg, else 0,1,2,3,4.
- R9: On a successful result `cfgWord1[31:16]` is 0x042C and `cfgWord1[15]` is zero.
- R10: A start raised while `busy` is high is ignored, and the running request completes with its own operands.
- R11: Result words and `error` stay unchanged from one completion until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| mode | input | 2 | Robust mode select (0, 1, 2; 3 is invalid) |
| carrierCount | input | 12 | Number of active carriers |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last request was rejected |
| cfgWord0 | output | 32 | Segment bits [31:16], pad count [15:0] |
| cfgWord1 | output | 32 | Max-carrier field [31:16], cyclic shifts [14:0] |

## Verification
A rejected request must show `done` and `error` one edge after the start edge. An accepted request must show `busy` from the next edge and `done` with new words 51 edges after the start edge. The bench keeps a behavioural model that counts those same edges from each start it sees. On every falling edge it compares `busy`, `done`, `error` and each field of both words against the model, so an early, late or doubled pulse is seen in the cycle it happens. The operand sets cover each shift branch of every mode. They include an exact-multiple remainder, the minimum valid carrier count, a start while busy and a start issued in the `done` cycle.

// File: rtl/robo_ilv_pkg.sv
package robo_ilv_pkg;
  localparam int CAR_W      = 12;
  localparam int DIV_W      = 16;
  localparam int SH_W       = 3;
  localparam int MAX_COPIES = 5;
  localparam int LATENCY    = 3 * DIV_W + 3;
  localparam logic [15:0] MAX_CARRIER = 16'h042C;

  typedef struct packed {
    logic       loadDiv;
    logic [1:0] divSel;
    logic       capSeg;
    logic       capLast;
    logic       finish;
    logic       failNow;
  } strobeT;

  function automatic logic [2:0] copiesOf(input logic [1:0] m);
    case (m)
      2'd0:    copiesOf = 3'd4;
      2'd1:    copiesOf = 3'd2;
      2'd2:    copiesOf = 3'd5;
      default: copiesOf = 3'd0;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] rawOf(input logic [1:0] m);
    case (m)
      2'd0, 2'd1: rawOf = DIV_W'(8320);
      2'd2:       rawOf = DIV_W'(2176);
      default:    rawOf = '0;
    endcase
  endfunction
endpackage

// File: rtl/robo_ilv_divider.sv
module robo_ilv_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         ready,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cntR;
  logic [W-1:0]     remR, quoR, divR;
  logic [W:0]       trial, diff;

  assign trial = {remR, quoR[W-1]};
  assign diff  = trial - {1'b0, divR};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntR <= '0;
      remR <= '0;
      quoR <= '0;
      divR <= '0;
    end else if (load) begin
      cntR <= CNT_W'(W);
      remR <= '0;
      quoR <= dividend;
      divR <= divisor;
    end else if (cntR != '0) begin
      cntR <= cntR - 1'b1;
      if (!diff[W]) begin
        remR <= diff[W-1:0];
        quoR <= {quoR[W-2:0], 1'b1};
      end else begin
        remR <= trial[W-1:0];
        quoR <= {quoR[W-2:0], 1'b0};
      end
    end
  end

  assign ready     = (cntR == '0);
  assign quotient  = quoR;
  assign remainder = remR;

  // R3: a fresh load always takes cycles before its result is ready
  assert_load_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
endmodule

// File: rtl/robo_ilv_ctrl.sv
module robo_ilv_ctrl
  import robo_ilv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   opsOk,
  input  logic   divReady,
  output strobeT strobe,
  output logic   busy
);
  typedef enum logic [1:0] {S_IDLE, S_QUOT, S_MOD, S_SEG} stateT;
  stateT stateR, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = stateR;
    case (stateR)
      S_IDLE: if (start) begin
        if (opsOk) begin
          strobe.loadDiv = 1'b1;
          strobe.divSel  = 2'd0;
          stateNxt       = S_QUOT;
        end else begin
          strobe.failNow = 1'b1;
        end
      end
      S_QUOT: if (divReady) begin
        strobe.capSeg  = 1'b1;
        strobe.loadDiv = 1'b1;
        strobe.divSel  = 2'd1;
        stateNxt       = S_MOD;
      end
      S_MOD: if (divReady) begin
        strobe.capLast = 1'b1;
        strobe.loadDiv = 1'b1;
        strobe.divSel  = 2'd2;
        stateNxt       = S_SEG;
      end
      default: if (divReady) begin
        strobe.finish = 1'b1;
        stateNxt      = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateR <= S_IDLE;
    else        stateR <= stateNxt;
  end

  assign busy = (stateR != S_IDLE);

  // R10: a request in flight leaves the idle state only through completion
  assert_busy_runs_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !divReady) |=> busy);
endmodule

// File: rtl/robo_ilv_datapath.sv
module robo_ilv_datapath
  import robo_ilv_pkg::*;
#(
  parameter int CW = CAR_W,
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobeT        strobe,
  input  logic [1:0]    modeIn,
  input  logic [CW-1:0] carrierIn,
  output logic          opsOk,
  output logic          divReady,
  output logic          done,
  output logic          error,
  output logic [31:0]   word0,
  output logic [31:0]   word1
);
  localparam int SHF_W = MAX_COPIES * SH_W;

  logic [1:0]    modeR;
  logic [DW-1:0] bsegR, bsymR, lastEffR;
  logic [DW-1:0] divDividend, divDivisor, quo, rem;
  logic [DW-1:0] bsegNext, bsymNext, lastEffNext, padNext;
  logic [SHF_W-1:0] shiftField;

  function automatic logic [DW-1:0] mulCopies(input logic [DW-1:0] v, input logic [1:0] m);
    case (copiesOf(m))
      3'd4:    mulCopies = v << 2;
      3'd2:    mulCopies = v << 1;
      3'd5:    mulCopies = (v << 2) + v;
      default: mulCopies = '0;
    endcase
  endfunction

  assign opsOk = (modeIn != 2'd3) && (DW'(carrierIn) >= DW'(copiesOf(modeIn)));

  assign bsegNext    = quo << 1;
  assign bsymNext    = mulCopies(bsegNext, modeR);
  assign lastEffNext = (rem == '0) ? bsymR : rem;
  assign padNext     = bsegR - rem - 1'b1;

  always_comb begin
    case (strobe.divSel)
      2'd0: begin
        divDividend = DW'(carrierIn);
        divDivisor  = DW'(copiesOf(modeIn));
      end
      2'd1: begin
        divDividend = rawOf(modeR);
        divDivisor  = bsymNext;
      end
      default: begin
        divDividend = lastEffNext - 1'b1;
        divDivisor  = bsegR;
      end
    endcase
  end

  robo_ilv_divider #(.W(DW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (strobe.loadDiv),
    .dividend  (divDividend),
    .divisor   (divDivisor),
    .ready     (divReady),
    .quotient  (quo),
    .remainder (rem)
  );

  // cyclic shift per copy from how many segments the last symbol fills
  always_comb begin
    logic [DW+2:0] sE, s2, s3, s4, lE;
    logic [SH_W-1:0] v;
    sE = (DW+3)'(bsegR);
    s2 = sE << 1;
    s3 = sE + s2;
    s4 = sE << 2;
    lE = (DW+3)'(lastEffR);
    shiftField = '0;
    for (int k = 0; k < MAX_COPIES; k++) begin
      v = '0;
      case (modeR)
        2'd0: if (k < 4) begin
          if (lE <= sE)      v = '0;
          else if (lE <= s2) v = SH_W'(k >> 1);
          else if (lE <= s3) v = '0;
          else               v = SH_W'(k);
        end
        2'd1: if (k < 2 && lE > sE) v = SH_W'(k);
        2'd2: if (lE > s4) v = SH_W'(k);
        default: v = '0;
      endcase
      shiftField[k*SH_W +: SH_W] = v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeR    <= '0;
      bsegR    <= '0;
      bsymR    <= '0;
      lastEffR <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      word0    <= '0;
      word1    <= '0;
    end else begin
      done <= strobe.finish | strobe.failNow;
      if (strobe.loadDiv && strobe.divSel == 2'd0) modeR <= modeIn;
      if (strobe.capSeg) begin
        bsegR <= bsegNext;
        bsymR <= bsymNext;
      end
      if (strobe.capLast) lastEffR <= lastEffNext;
      if (strobe.failNow) begin
        error <= 1'b1;
        word0 <= '0;
        word1 <= '0;
      end else if (strobe.finish) begin
        error <= 1'b0;
        word0 <= {16'(bsegR), 16'(padNext)};
        word1 <= {MAX_CARRIER, 16'(shiftField)};
      end
    end
  end

  // R2: a rejected request leaves both words cleared
  assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (word0 == '0 && word1 == '0));
  // R5: the pad count is always shorter than a segment
  assert_pad_lt_seg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (word0[15:0] < word0[31:16]));
  // R9: every good result carries the fixed max-carrier field
  assert_maxcar_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (word1[31:15] == {MAX_CARRIER, 1'b0}));
endmodule

// File: rtl/robo_ilv_calc.sv
module robo_ilv_calc
  import robo_ilv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CAR_W-1:0] carrierCount,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [31:0]      cfgWord0,
  output logic [31:0]      cfgWord1
);
  strobeT strobe;
  logic   opsOk, divReady;

  robo_ilv_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opsOk    (opsOk),
    .divReady (divReady),
    .strobe   (strobe),
    .busy     (busy)
  );

  robo_ilv_datapath #(.CW(CAR_W), .DW(DIV_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .modeIn    (mode),
    .carrierIn (carrierCount),
    .opsOk     (opsOk),
    .divReady  (divReady),
    .done      (done),
    .error     (error),
    .word0     (cfgWord0),
    .word1     (cfgWord1)
  );

  // R3: completion is never reported while still working
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11: results only move in the edge that also raises done
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(cfgWord0) && $stable(cfgWord1) && $stable(error))));
endmodule

// File: tb/robo_ilv_calc_bench.sv
module robo_ilv_calc_bench;
  localparam int LAT = 51;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [11:0] carrierCount = '0;
  logic        busy, done, error;
  logic [31:0] cfgWord0, cfgWord1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  robo_ilv_calc u_robo_ilv_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .carrierCount(carrierCount), .busy(busy), .done(done), .error(error),
    .cfgWord0(cfgWord0), .cfgWord1(cfgWord1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void refCalc(input int m, input int c, output bit e,
                                  output logic [31:0] w0, output logic [31:0] w1,
                                  output string tag);
    int n, raw, seg, sym, lastSym, lastSeg, pad;
    int sh [5];
    n = (m == 0) ? 4 : (m == 1) ? 2 : (m == 2) ? 5 : 0;
    tag = (m == 0) ? "R6" : (m == 1) ? "R7" : "R8";
    w0 = 0; w1 = 0; e = 0;
    if (n == 0 || c < n) begin e = 1; return; end
    raw = (m == 2) ? 2176 : 8320;
    seg = 2 * (c / n);
    sym = seg * n;
    lastSym = raw % sym;
    if (lastSym == 0) begin lastSym = sym; lastSeg = seg; end
    else lastSeg = lastSym - seg * ((lastSym - 1) / seg);
    pad = seg - lastSeg;
    foreach (sh[k]) sh[k] = 0;
    if (m == 0) begin
      if (lastSym <= seg) ;
      else if (lastSym <= 2*seg) begin sh[2] = 1; sh[3] = 1; end
      else if (lastSym <= 3*seg) ;
      else for (int k = 0; k < 4; k++) sh[k] = k;
    end else if (m == 1) begin
      if (lastSym > seg) sh[1] = 1;
    end else begin
      if (lastSym > 4*seg) for (int k = 0; k < 5; k++) sh[k] = k;
    end
    w0 = {seg[15:0], pad[15:0]};
    w1 = 32'h042C_0000;
    for (int k = 0; k < 5; k++) w1 = w1 | (32'(sh[k]) << (3*k));
  endfunction

  // behavioural reference, advanced once per rising edge
  bit          busyM, doneM, errM;
  int          remM;
  logic [31:0] w0M, w1M, pw0, pw1;
  string       tagM = "R6", pTag;

  always @(posedge clk) begin
    bit pe; logic [31:0] a0, a1; string t;
    if (!rst_n) begin
      busyM = 0; doneM = 0; errM = 0; remM = 0; w0M = 0; w1M = 0;
    end else begin
      doneM = 0;
      if (busyM) begin
        remM--;
        if (remM == 0) begin
          busyM = 0; doneM = 1; errM = 0; w0M = pw0; w1M = pw1; tagM = pTag;
        end
      end else if (start) begin
        refCalc(int'(mode), int'(carrierCount), pe, a0, a1, t);
        if (pe) begin
          doneM = 1; errM = 1; w0M = 0; w1M = 0;
        end else begin
          busyM = 1; remM = LAT; pw0 = a0; pw1 = a1; pTag = t;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 busy", 32'(busy), 32'(busyM));
      chk("R3 done", 32'(done), 32'(doneM));
      chk("R2 error", 32'(error), 32'(errM));
      chk("R4 segment", 32'(cfgWord0[31:16]), 32'(w0M[31:16]));
      chk("R5 pad", 32'(cfgWord0[15:0]), 32'(w0M[15:0]));
      chk({tagM, " shifts"}, 32'(cfgWord1[15:0]), 32'(w1M[15:0]));
      chk("R9 maxcarrier", 32'(cfgWord1[31:16]), 32'(w1M[31:16]));
    end
  end

  task automatic issue(input int m, input int c);
    @(negedge clk);
    start = 1'b1; mode = 2'(m); carrierCount = 12'(c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 100; i++) begin
      if (done) return;
      @(negedge clk);
    end
  endtask

  task automatic run(input int m, input int c);
    issue(m, c);
    waitDone();
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    bit e; logic [31:0] x0, x1, h0, h1; string t;
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk("R1 reset", {busy, done, error, 29'd0}, 32'd0);
    chk("R1 reset w0", cfgWord0, 32'd0);
    chk("R1 reset w1", cfgWord1, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", cfgWord0 | cfgWord1, 32'd0);

    run(0, 4095);  // R6 last symbol within one segment
    run(0, 3200);  // R6 within two segments
    run(0, 917);   // R6 within three segments
    run(0, 1044);  // R6 beyond three segments
    run(0, 1040);  // R5 exact multiple, zero pad
    run(1, 2000);  // R7 one segment
    run(1, 917);   // R7 beyond one segment
    run(2, 917);   // R8 within four segments
    run(2, 550);   // R8 beyond four segments
    run(2, 5);     // R2 minimum valid count
    run(3, 100);   // R2 invalid mode code
    run(2, 4);     // R2 carriers below copies
    run(0, 3);     // R2

    // R10: second start while busy is ignored
    issue(0, 917);
    repeat (10) @(negedge clk);
    issue(1, 2000);
    waitDone();
    refCalc(0, 917, e, x0, x1, t);
    chk("R10 ignored start", cfgWord0, x0);

    // R11: results hold after completion
    h0 = cfgWord0; h1 = cfgWord1;
    repeat (20) @(negedge clk);
    chk("R11 hold w0", cfgWord0, h0);
    chk("R11 hold w1", cfgWord1, h1);

    // R3: start issued in the done cycle is accepted
    issue(1, 917);
    waitDone();
    start = 1'b1; mode = 2'd2; carrierCount = 12'd550;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    refCalc(2, 550, e, x0, x1, t);
    chk("R3 back-to-back", cfgWord1, x1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule